// File: doc/BRIEF.md
# Coarse-Tuning Channel Bin Selector

This block sits between a frequency channelizer and a bank of narrowband receive channels. The channelizer delivers its bins as one time-multiplexed complex stream, each sample tagged with its bin index. The bins of one frame arrive in ascending order, and idle cycles may fall between them. The selector captures each complete frame in a ping-pong frame memory. It then sweeps the output channels in ascending order. For each channel it reads the single bin named by the top bits of that channel's 32-bit tuning word.

Any channel may pick any bin, and several channels may pick the same one. The output is a time-multiplexed complex stream tagged with the channel index. Each output sample carries the low, unused bits of the tuning word so that a downstream stage can do the fine tuning. Tuning words are loaded through a simple write port. A new word waits in a shadow copy until the current frame closes, so a channel never switches bins within one sweep.

Top module: `chan_bin_selector`

## Requirements
- R1: After reset, `out_valid` is 0, `out_chan`, `out_i`, `out_q` and `out_fine` are 0, and `out_valid` stays 0 until the first frame after reset has been completed by accepting bin index NUM_BINS-1.
- R2: When a sample with bin index NUM_BINS-1 is accepted on a clock edge, `out_valid` is 1 for exactly NUM_CHANS consecutive cycles, starting two edges later, with `out_chan` stepping 0, 1, ..., NUM_CHANS-1. Outside a sweep `out_valid` is 0.
- R3: The sample emitted for channel c is the I/Q pair that was accepted for bin b in the frame most recently completed. Here b is the top log2(NUM_BINS) bits of channel c's active tuning word, with bit 31 as the most significant.
- R4: Selection is nonblocking: any channel may select any bin, including 0 and NUM_BINS-1, and several channels may select the same bin in one sweep.
- R5: `out_fine` equals the low 32-log2(NUM_BINS) bits of the active tuning word of the channel being emitted.
- R6: A tuning-word write (`cfg_we`=1, channel `cfg_addr`) becomes active when the next frame completes. A write in the same cycle as the completing sample becomes active only at the frame completion after that. Until then the channel keeps its previous word.
- R7: Samples accepted for the frame under capture do not change the outputs of the sweep in progress, which reads only the frame already completed.
- R8: After reset every tuning word is 0, so every channel selects bin 0 with fine bits 0.
- R9: A cycle with `in_valid`=0 writes nothing, whatever the values of `in_bin`, `in_i` and `in_q`. Frames with idle cycles between bins are captured exactly as frames without idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bin sample present |
| in_bin | input | log2(NUM_BINS) | Bin index of the input sample |
| in_i | input | SAMP_W | In-phase part of the input sample |
| in_q | input | SAMP_W | Quadrature part of the input sample |
| cfg_we | input | 1 | Tuning-word write strobe |
| cfg_addr | input | log2(NUM_CHANS) | Channel whose tuning word is written |
| cfg_data | input | TW_W | Tuning word to write |
| out_valid | output | 1 | Output sample present |
| out_chan | output | log2(NUM_CHANS) | Channel index of the output sample |
| out_i | output | SAMP_W | In-phase part of the selected bin |
| out_q | output | SAMP_W | Quadrature part of the selected bin |
| out_fine | output | TW_W-log2(NUM_BINS) | Fine-tuning bits of the channel's word |

## Verification
The checks take for granted that the input stream starts at bin 0 after reset and that accepted bin indices step by exactly one, wrapping from NUM_BINS-1 to 0. As a result, a frame never completes faster than one bin per cycle, so a sweep always ends before the next one starts. The stimulus drives only whole frames in ascending bin order. It inserts idle cycles between bins, with junk on the data and index lines during those cycles. It changes tuning words at arbitrary points of a frame, including the completing cycle. All NUM_CHANS is kept below NUM_BINS.

// File: rtl/chbs_pkg.sv
package chbs_pkg;

   // Identifies one half of the ping-pong frame memory.
   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_t;

   function automatic bank_t other_bank(input bank_t b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction

endpackage

// File: rtl/chbs_frame_buffer.sv
module chbs_frame_buffer
   import chbs_pkg::*;
#(
   parameter  int NUM_BINS = 1024,
   parameter  int DATA_W   = 32,
   localparam int BIN_W    = $clog2(NUM_BINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  bank_t             wr_bank,
   input  logic [BIN_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  bank_t             rd_bank,
   input  logic [BIN_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 2 * NUM_BINS;

   logic [DATA_W-1:0] mem [DEPTH];

   // Write port: no reset on the storage array.
   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[{wr_bank == BANK_B, wr_addr}] <= wr_data;
      end
   end

   // Registered read port; it holds its value between reads.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= mem[{rd_bank == BANK_B, rd_addr}];
      end
   end

endmodule

// File: rtl/chbs_tune_regs.sv
module chbs_tune_regs #(
   parameter  int NUM_CHANS = 256,
   parameter  int TW_W      = 32,
   localparam int CH_W      = $clog2(NUM_CHANS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CH_W-1:0] wr_addr,
   input  logic [TW_W-1:0] wr_data,
   input  logic            commit,
   input  logic [CH_W-1:0] rd_addr,
   output logic [TW_W-1:0] rd_word
);

   logic [TW_W-1:0] active_w [NUM_CHANS];

   for (genvar c = 0; c < NUM_CHANS; c++) begin : g_ch
      logic [TW_W-1:0] shadow_q;
      logic [TW_W-1:0] active_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
         end else begin
            if (wr_en && (wr_addr == CH_W'(c))) begin
               shadow_q <= wr_data;
            end
            // The committed word is the shadow value from before this cycle's write.
            if (commit) begin
               active_q <= shadow_q;
            end
         end
      end

      assign active_w[c] = active_q;
   end

   assign rd_word = active_w[rd_addr];

endmodule

// File: rtl/chbs_sweep_ctrl.sv
module chbs_sweep_ctrl
   import chbs_pkg::*;
#(
   parameter  int NUM_BINS  = 1024,
   parameter  int NUM_CHANS = 256,
   localparam int BIN_W     = $clog2(NUM_BINS),
   localparam int CH_W      = $clog2(NUM_CHANS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [BIN_W-1:0] in_bin,
   output logic             frame_done,
   output bank_t            wr_bank,
   output bank_t            rd_bank,
   output logic             rd_en,
   output logic [CH_W-1:0]  rd_chan
);

   localparam logic [BIN_W-1:0] LAST_BIN  = BIN_W'(NUM_BINS - 1);
   localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(NUM_CHANS - 1);

   bank_t           wr_bank_q;
   logic            run_q;
   logic [CH_W-1:0] chan_q;

   assign frame_done = in_valid && (in_bin == LAST_BIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank_q <= BANK_A;
      end else if (frame_done) begin
         wr_bank_q <= other_bank(wr_bank_q);
      end
   end

   // One channel per cycle; a completed frame (re)starts the sweep at channel 0.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         chan_q <= '0;
      end else if (frame_done) begin
         run_q  <= 1'b1;
         chan_q <= '0;
      end else if (run_q) begin
         if (chan_q == LAST_CHAN) begin
            run_q <= 1'b0;
         end else begin
            chan_q <= chan_q + 1'b1;
         end
      end
   end

   assign wr_bank = wr_bank_q;
   assign rd_bank = other_bank(wr_bank_q);
   assign rd_en   = run_q;
   assign rd_chan = chan_q;

endmodule

// File: rtl/chan_bin_selector.sv
module chan_bin_selector
   import chbs_pkg::*;
#(
   parameter  int NUM_BINS  = 1024,
   parameter  int NUM_CHANS = 256,
   parameter  int TW_W      = 32,
   parameter  int SAMP_W    = 16,
   localparam int BIN_W     = $clog2(NUM_BINS),
   localparam int CH_W      = $clog2(NUM_CHANS),
   localparam int FINE_W    = TW_W - BIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BIN_W-1:0]  in_bin,
   input  logic [SAMP_W-1:0] in_i,
   input  logic [SAMP_W-1:0] in_q,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_addr,
   input  logic [TW_W-1:0]   cfg_data,
   output logic              out_valid,
   output logic [CH_W-1:0]   out_chan,
   output logic [SAMP_W-1:0] out_i,
   output logic [SAMP_W-1:0] out_q,
   output logic [FINE_W-1:0] out_fine
);

   localparam int DATA_W = 2 * SAMP_W;

   // Elaboration-time parameter checks.
   if (NUM_BINS < 2 || (1 << BIN_W) != NUM_BINS) begin : g_bad_bins
      $error("NUM_BINS must be a power of two of at least 2");
   end
   if (NUM_CHANS < 2 || (1 << CH_W) != NUM_CHANS) begin : g_bad_chans
      $error("NUM_CHANS must be a power of two of at least 2");
   end
   if (NUM_CHANS > NUM_BINS) begin : g_bad_ratio
      $error("NUM_CHANS must not exceed NUM_BINS so a sweep ends within a frame");
   end
   if (FINE_W < 1) begin : g_bad_tw
      $error("TW_W must be wider than the bin index");
   end
   if (SAMP_W < 1) begin : g_bad_samp
      $error("SAMP_W must be at least 1");
   end

   logic              frame_done;
   bank_t             wr_bank;
   bank_t             rd_bank;
   logic              rd_en;
   logic [CH_W-1:0]   rd_chan;
   logic [TW_W-1:0]   rd_word;
   logic [BIN_W-1:0]  sel_bin;
   logic [DATA_W-1:0] rd_data;

   chbs_sweep_ctrl #(
      .NUM_BINS  (NUM_BINS),
      .NUM_CHANS (NUM_CHANS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_bin     (in_bin),
      .frame_done (frame_done),
      .wr_bank    (wr_bank),
      .rd_bank    (rd_bank),
      .rd_en      (rd_en),
      .rd_chan    (rd_chan)
   );

   chbs_tune_regs #(
      .NUM_CHANS (NUM_CHANS),
      .TW_W      (TW_W)
   ) u_tune (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_data),
      .commit  (frame_done),
      .rd_addr (rd_chan),
      .rd_word (rd_word)
   );

   // Coarse selection: the top bits of the tuning word name the bin.
   assign sel_bin = rd_word[TW_W-1 -: BIN_W];

   chbs_frame_buffer #(
      .NUM_BINS (NUM_BINS),
      .DATA_W   (DATA_W)
   ) u_fbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_bank (wr_bank),
      .wr_addr (in_bin),
      .wr_data ({in_i, in_q}),
      .rd_en   (rd_en),
      .rd_bank (rd_bank),
      .rd_addr (sel_bin),
      .rd_data (rd_data)
   );

   // Tags aligned with the registered memory read.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_fine  <= '0;
      end else begin
         out_valid <= rd_en;
         if (rd_en) begin
            out_chan <= rd_chan;
            out_fine <= rd_word[FINE_W-1:0];
         end
      end
   end

   assign out_i = rd_data[DATA_W-1 -: SAMP_W];
   assign out_q = rd_data[SAMP_W-1:0];

endmodule

// File: rtl/chbs_checker.sv
module chbs_checker #(
   parameter  int NUM_BINS  = 1024,
   parameter  int NUM_CHANS = 256,
   localparam int BIN_W     = $clog2(NUM_BINS),
   localparam int CH_W      = $clog2(NUM_CHANS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [BIN_W-1:0] in_bin,
   input logic             out_valid,
   input logic [CH_W-1:0]  out_chan
);

   localparam logic [BIN_W-1:0] LAST_BIN  = BIN_W'(NUM_BINS - 1);
   localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(NUM_CHANS - 1);

   logic [BIN_W-1:0] next_bin_q;
   logic             frame_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_bin_q   <= '0;
         frame_seen_q <= 1'b0;
      end else if (in_valid) begin
         next_bin_q <= (in_bin == LAST_BIN) ? '0 : in_bin + 1'b1;
         if (in_bin == LAST_BIN) begin
            frame_seen_q <= 1'b1;
         end
      end
   end

   // Input contract the rest relies on (R9: bins in order, gaps allowed).
   a_r9_bins_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> in_bin == next_bin_q);

   // R1: silent until one whole frame has been taken in.
   a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> frame_seen_q);

   // R2: a completed frame starts a sweep at channel 0 two edges later.
   a_r2_sweep_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_bin == LAST_BIN) |=> ##1 (out_valid && out_chan == '0));

   // R2: a sweep can only begin at channel 0.
   a_r2_first_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_chan == '0);

   // R2: channels step by one with no holes.
   a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_chan != LAST_CHAN) |=>
         (out_valid && out_chan == CH_W'($past(out_chan) + 1'b1)));

   // R2: after the last channel the sweep ends (or a new one begins at 0).
   a_r2_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_chan == LAST_CHAN) |=> (!out_valid || out_chan == '0));

endmodule

bind chan_bin_selector chbs_checker #(
   .NUM_BINS  (NUM_BINS),
   .NUM_CHANS (NUM_CHANS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_bin    (in_bin),
   .out_valid (out_valid),
   .out_chan  (out_chan)
);

// File: tb/sim_chan_bin_selector.sv
module sim_chan_bin_selector;

   localparam int CLK_PERIOD = 10;
   localparam int NB   = 16;
   localparam int NC   = 8;
   localparam int TW   = 32;
   localparam int SW   = 12;
   localparam int BW   = $clog2(NB);
   localparam int CW   = $clog2(NC);
   localparam int FW   = TW - BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [BW-1:0] in_bin = '0;
   logic [SW-1:0] in_i = '0;
   logic [SW-1:0] in_q = '0;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_addr = '0;
   logic [TW-1:0] cfg_data = '0;
   logic          out_valid;
   logic [CW-1:0] out_chan;
   logic [SW-1:0] out_i;
   logic [SW-1:0] out_q;
   logic [FW-1:0] out_fine;

   always #(CLK_PERIOD / 2) clk = ~clk;

   chan_bin_selector #(
      .NUM_BINS (NB), .NUM_CHANS (NC), .TW_W (TW), .SAMP_W (SW)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_bin (in_bin),
      .in_i (in_i), .in_q (in_q), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
      .cfg_data (cfg_data), .out_valid (out_valid), .out_chan (out_chan),
      .out_i (out_i), .out_q (out_q), .out_fine (out_fine)
   );

   // Behavioural reference model.
   typedef struct {
      bit          v;
      int          ch;
      int          i;
      int          q;
      logic [31:0] fine;
      string       tag;
   } exp_t;

   typedef struct {
      int          addr;
      logic [31:0] data;
   } wr_t;

   exp_t        exp_q[$];
   wr_t         wr_q[$];
   int          frm_i[NB];
   int          frm_q[NB];
   logic [31:0] shadow[NC];
   logic [31:0] active[NC];
   string       phase = "R1";
   int          vectors = 0;
   int          miscompares = 0;

   task automatic fail(input string tag, input string what, input longint act, input longint expv);
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
   endtask

   task automatic cmp(input string tag, input string what, input longint act, input longint expv);
      vectors++;
      if (act != expv) fail(tag, what, act, expv);
   endtask

   task automatic check_outputs();
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
         e.v = 0; e.ch = 0; e.i = 0; e.q = 0; e.fine = 0; e.tag = phase;
      end
      cmp(e.tag, "out_valid (R2)", longint'(out_valid), longint'(e.v));
      if (e.v && out_valid) begin
         cmp(e.tag, "out_chan (R2)", longint'(out_chan), longint'(e.ch));
         cmp(e.tag, "out_i (R3)", longint'(out_i), longint'(e.i));
         cmp(e.tag, "out_q (R3)", longint'(out_q), longint'(e.q));
         cmp(e.tag, "out_fine (R5)", longint'(out_fine), longint'(e.fine));
      end
   endtask

   // Queue slot 0 is the next check; a sweep shows up from slot 1 on.
   task automatic schedule_sweep();
      exp_t e;
      if (exp_q.size() == 0) begin
         e.v = 0; e.ch = 0; e.i = 0; e.q = 0; e.fine = 0; e.tag = phase;
         exp_q.push_back(e);
      end
      for (int c = 0; c < NC; c++) begin
         int b;
         b      = int'(active[c] >> FW);
         e.v    = 1;
         e.ch   = c;
         e.i    = frm_i[b];
         e.q    = frm_q[b];
         e.fine = active[c] & ((32'h1 << FW) - 1);
         e.tag  = phase;
         exp_q.push_back(e);
      end
   endtask

   // One cycle: check the last edge's result, then drive the next edge.
   task automatic step(input bit v, input int b, input bit wr_now);
      wr_t w;
      @(negedge clk);
      check_outputs();
      in_valid = v;
      in_bin   = v ? BW'(b) : BW'($urandom);
      in_i     = SW'($urandom);
      in_q     = SW'($urandom);
      cfg_we   = 1'b0;
      if (wr_now && wr_q.size() > 0) begin
         w        = wr_q.pop_front();
         cfg_we   = 1'b1;
         cfg_addr = CW'(w.addr);
         cfg_data = w.data;
      end
      if (v) begin
         frm_i[b] = int'(in_i);
         frm_q[b] = int'(in_q);
         if (b == NB - 1) begin
            for (int c = 0; c < NC; c++) active[c] = shadow[c];
            schedule_sweep();
         end
      end
      if (cfg_we) shadow[int'(cfg_addr)] = cfg_data;
   endtask

   // One frame with idle cycles at the given percentage; writes drain early
   // unless held back for the completing cycle.
   task automatic run_frame(input int gap_pct, input bit write_at_last);
      for (int b = 0; b < NB; b++) begin
         while (($urandom % 100) < gap_pct) step(1'b0, 0, !write_at_last);
         step(1'b1, b, !write_at_last || (b == NB - 1));
      end
   endtask

   task automatic queue_write(input int ch, input int bin, input logic [31:0] fine);
      wr_t w;
      w.addr = ch;
      w.data = (32'(bin) << FW) | (fine & ((32'h1 << FW) - 1));
      wr_q.push_back(w);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : stimulus
      for (int c = 0; c < NC; c++) begin
         shadow[c] = '0;
         active[c] = '0;
      end
      for (int b = 0; b < NB; b++) begin
         frm_i[b] = 0;
         frm_q[b] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values on every output.
      cmp("R1", "reset out_valid", longint'(out_valid), 0);
      cmp("R1", "reset out_chan", longint'(out_chan), 0);
      cmp("R1", "reset out_i", longint'(out_i), 0);
      cmp("R1", "reset out_q", longint'(out_q), 0);
      cmp("R1", "reset out_fine", longint'(out_fine), 0);

      // R1: quiet during the first frame; R8: its sweep uses all-zero words.
      phase = "R1 first frame";
      for (int b = 0; b < NB - 1; b++) step(1'b1, b, 1'b0);
      phase = "R8 default words";
      step(1'b1, NB - 1, 1'b0);

      // R6: writes land while the zero-word sweep runs; R4: shared and edge bins.
      queue_write(0, NB - 1, 32'h0ABC_DEF1);
      queue_write(1, 0,      32'h0123_4567);
      queue_write(2, 5,      32'h0555_0000);
      queue_write(3, 5,      32'h0000_0AAA);
      queue_write(4, 5,      32'h0FFF_FFFF);
      queue_write(5, 9,      32'h0000_0001);
      queue_write(6, 3,      32'h0765_4321);
      queue_write(7, NB - 1, 32'h0000_0000);
      phase = "R6 deferred words";
      run_frame(0, 1'b0);

      // R9: idle cycles with junk inputs; R4/R5/R3 with the new words.
      phase = "R4 R5 R9 gapped frame";
      run_frame(50, 1'b0);

      // R6: write in the completing cycle is held one more frame.
      queue_write(5, 12, 32'h0BAD_CAFE);
      phase = "R6 write at frame end";
      run_frame(20, 1'b1);
      phase = "R6 write now active";
      run_frame(0, 1'b0);

      // R7: fresh frame data captured while each sweep runs.
      for (int f = 0; f < 6; f++) begin
         for (int k = 0; k < 3; k++) begin
            queue_write(int'($urandom % NC), int'($urandom % NB), $urandom);
         end
         phase = "R7 capture during sweep";
         run_frame(f * 10, 1'b0);
      end

      phase = "R2 drain";
      for (int k = 0; k < NC + 4; k++) step(1'b0, 0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule